// File: doc/BRIEF.md
# Differential Clock Stop and Power-Down Controller

This block gates a set of identical clock copies onto true/complement output pairs and decides, pair by pair, whether each pair toggles, is parked, or floats. The clock being distributed is half the block clock `clk`. An internal phase register `ph` toggles every cycle. While a pair runs, its true line equals `ph` and its complement line equals `~ph`. A "complement rising edge" is therefore a clock edge at which `ph` goes from 1 to 0. A "complement falling edge" is a clock edge at which `ph` goes from 0 to 1.

Three controls act on the pairs:
- An active-low power-down request parks every pair.
- An active-low stop request parks only the pairs marked stoppable.
- Per-pair enable pins switch individual pairs off. A polarity input, latched while reset is asserted, decides whether these pins are active high or active low.

The two requests are asynchronous. Each passes through a two-flop synchronizer and is then qualified on complement rising edges. Two register bits choose whether a parked pair is driven or floating. Every change of a pair's state is committed at a phase boundary, so no shortened pulse reaches an output.

Top module: `ckgate_ctrl`

## Requirements
- R1: The power-down request `pd_req_n` (0 = request) takes effect only after its synchronized value reads low on two consecutive complement rising edges. A pulse one clock long is ignored, and running pairs keep toggling.
- R2: Once power-down is accepted, all pairs park at the next complement falling edge. The complement line of a running pair is high in the sample just before parking.
- R3: While powered down, every pair shows the same state regardless of enable and stop settings. With `pd_float`=0: true line = 1 and driven, complement = 0 and undriven. With `pd_float`=1: both lines are 0 and undriven.
- R4: The stop request `stop_req_n` (0 = stop) changes its accepted value only when two consecutive complement-rising-edge samples agree. A one-cycle pulse in either direction is ignored.
- R5: A stopped pair with `stop_float`=0 shows true = 1 driven and complement = 0 undriven. With `stop_float`=1 it shows both lines at 0 and undriven.
- R6: After the stop request is released, all stopped pairs return to driven toggling in the same cycle. This happens between 4 and 12 clock cycles (2 to 6 output periods) after the release.
- R7: A pair whose `free_run` bit is 1 keeps toggling while a stop is accepted.
- R8: A pair is enabled when `oe_pin[i]` XOR the latched polarity equals 1. A disabled pair shows both lines at 0 and undriven. Enable and disable take effect only on a clock edge where true goes from 1 to 0. A running pair shows `dif_c == ~dif_t` with both lines driven, and its true line toggles every cycle.
- R9: The polarity input `oe_inv` is captured while `rst` is high and held afterwards. Later changes on it have no effect.
- R10: While `rst` is high, every pair shows both lines at 0 and undriven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; output clocks run at half this rate |
| rst | input | 1 | Synchronous active-high reset |
| pd_req_n | input | 1 | Asynchronous power-down request, active low |
| stop_req_n | input | 1 | Asynchronous stop request, active low |
| oe_pin | input | N_OUT | Per-pair enable pins, polarity set by latched `oe_inv` |
| oe_inv | input | 1 | Enable polarity: 0 = active high, 1 = active low |
| pd_float | input | 1 | Power-down park style: 0 = true driven high, 1 = both floating |
| stop_float | input | 1 | Stop park style: 0 = true driven high, 1 = both low and floating |
| free_run | input | N_OUT | Per pair: 1 = ignores stop, 0 = stoppable |
| dif_t | output | N_OUT | True line level per pair |
| dif_c | output | N_OUT | Complement line level per pair |
| dif_t_oe | output | N_OUT | True line driven (1) or floating (0) |
| dif_c_oe | output | N_OUT | Complement line driven (1) or floating (0) |

## Verification
The embedded properties assume the following about the inputs:
- `pd_float`, `stop_float` and `free_run` stay static while pairs are parked.
- The requests reach the qualifiers only through the synchronizers, so the qualifiers see no metastable values.

The stimulus changes the mode bits only inside reset, and it moves requests and pins just after a falling clock edge. It holds each qualified request for many cycles, except for the deliberate one-cycle glitches. The sweep covers every combination of polarity and both park styles, and rotates which pairs are enabled and which run freely.

// File: rtl/ckgate_pkg.sv
package ckgate_pkg;

    // State a pair holds between phase boundaries
    typedef enum logic [1:0] {
        LANE_RUN  = 2'd0,
        LANE_STOP = 2'd1,
        LANE_OFF  = 2'd2
    } lane_mode_e;

    // Levels and drive enables of one true/complement pair
    typedef struct packed {
        logic t;
        logic c;
        logic t_oe;
        logic c_oe;
    } pair_drive_t;

    // Map a pair's committed state to its pin levels
    function automatic pair_drive_t lane_drive(
        input lane_mode_e m,
        input logic       pd,
        input logic       pd_flt,
        input logic       stop_flt,
        input logic       ph
    );
        pair_drive_t d;
        d = '0;
        if (pd) begin
            d.t    = !pd_flt;
            d.t_oe = !pd_flt;
        end else begin
            case (m)
                LANE_RUN: begin
                    d.t    = ph;
                    d.c    = !ph;
                    d.t_oe = 1'b1;
                    d.c_oe = 1'b1;
                end
                LANE_STOP: begin
                    d.t    = !stop_flt;
                    d.t_oe = !stop_flt;
                end
                default: d = '0;
            endcase
        end
        return d;
    endfunction

endpackage

// File: rtl/ckgate_sync.sv
module ckgate_sync #(
    parameter int           W       = 1,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] st [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) st[s] <= RST_VAL;
        end else begin
            st[0] <= d;
            for (int s = 1; s < STAGES; s++) st[s] <= st[s-1];
        end
    end

    assign q = st[STAGES-1];
endmodule

// File: rtl/ckgate_qual.sv
module ckgate_qual #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic raw_n,
    output logic acc_n
);
    logic sync_n;
    logic samp_q;
    logic acc_q;

    ckgate_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_n),
        .q   (sync_n)
    );

    // Two consecutive complement-rise samples must agree
    always_ff @(posedge clk) begin
        if (rst) begin
            samp_q <= 1'b1;
            acc_q  <= 1'b1;
        end else if (tick) begin
            samp_q <= sync_n;
            if (sync_n == samp_q) acc_q <= sync_n;
        end
    end

    assign acc_n = acc_q;

    p_acc_on_tick_r4: assert property (@(posedge clk) disable iff (rst)
        !$stable(acc_q) |-> $past(tick));

    p_acc_two_samples_r1: assert property (@(posedge clk) disable iff (rst)
        !$stable(acc_q) |-> ($past(samp_q) == acc_q) && ($past(sync_n) == acc_q));
endmodule

// File: rtl/ckgate_lane.sv
module ckgate_lane
    import ckgate_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        tick,
    input  logic        ph,
    input  logic        en,
    input  logic        free_run,
    input  logic        stop_act,
    input  logic        pd_park,
    input  logic        pd_float,
    input  logic        stop_float,
    output pair_drive_t drv
);
    lane_mode_e mode_q;
    lane_mode_e mode_d;

    always_comb begin
        if (!en)                        mode_d = LANE_OFF;
        else if (stop_act && !free_run) mode_d = LANE_STOP;
        else                            mode_d = LANE_RUN;
    end

    // Commit only where the true line falls, so pulses stay whole
    always_ff @(posedge clk) begin
        if (rst)       mode_q <= LANE_OFF;
        else if (tick) mode_q <= mode_d;
    end

    assign drv = lane_drive(mode_q, pd_park, pd_float, stop_float, ph);

    p_mode_on_tick_r8: assert property (@(posedge clk) disable iff (rst)
        !$stable(mode_q) |-> $past(tick));

    p_run_toggles_r8: assert property (@(posedge clk) disable iff (rst)
        (mode_q == LANE_RUN && $past(mode_q) == LANE_RUN && !pd_park && !$past(pd_park))
        |-> (drv.t != $past(drv.t)) && (drv.c == !drv.t));

    p_free_never_stops_r7: assert property (@(posedge clk) disable iff (rst)
        (free_run && $past(free_run)) |-> (mode_q != LANE_STOP));
endmodule

// File: rtl/ckgate_ctrl.sv
module ckgate_ctrl
    import ckgate_pkg::*;
#(
    parameter int N_OUT       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pd_req_n,
    input  logic             stop_req_n,
    input  logic [N_OUT-1:0] oe_pin,
    input  logic             oe_inv,
    input  logic             pd_float,
    input  logic             stop_float,
    input  logic [N_OUT-1:0] free_run,
    output logic [N_OUT-1:0] dif_t,
    output logic [N_OUT-1:0] dif_c,
    output logic [N_OUT-1:0] dif_t_oe,
    output logic [N_OUT-1:0] dif_c_oe
);
    logic             ph;
    logic             tick;
    logic             inv_q;
    logic             pd_acc_n;
    logic             stop_acc_n;
    logic             pd_park;
    logic [N_OUT-1:0] en_raw;
    logic [N_OUT-1:0] en_sync;
    pair_drive_t      lane_drv [N_OUT];

    // Output phase: true level of a running pair
    always_ff @(posedge clk) begin
        if (rst) ph <= 1'b0;
        else     ph <= !ph;
    end
    assign tick = ph;   // next edge is a complement rise

    // Polarity latched while reset is held
    always_ff @(posedge clk) begin
        if (rst) inv_q <= oe_inv;
    end

    assign en_raw = oe_pin ^ {N_OUT{inv_q}};

    ckgate_sync #(.W(N_OUT), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_en_sync (
        .clk (clk),
        .rst (rst),
        .d   (en_raw),
        .q   (en_sync)
    );

    ckgate_qual #(.SYNC_STAGES(SYNC_STAGES)) u_pd_qual (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .raw_n (pd_req_n),
        .acc_n (pd_acc_n)
    );

    ckgate_qual #(.SYNC_STAGES(SYNC_STAGES)) u_stop_qual (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .raw_n (stop_req_n),
        .acc_n (stop_acc_n)
    );

    // Power-down parks at a complement fall, releases at a complement rise
    always_ff @(posedge clk) begin
        if (rst)                   pd_park <= 1'b0;
        else if (!ph && !pd_acc_n) pd_park <= 1'b1;
        else if (ph && pd_acc_n)   pd_park <= 1'b0;
    end

    for (genvar i = 0; i < N_OUT; i++) begin : g_lane
        ckgate_lane u_lane (
            .clk        (clk),
            .rst        (rst),
            .tick       (tick),
            .ph         (ph),
            .en         (en_sync[i]),
            .free_run   (free_run[i]),
            .stop_act   (!stop_acc_n),
            .pd_park    (pd_park),
            .pd_float   (pd_float),
            .stop_float (stop_float),
            .drv        (lane_drv[i])
        );
        assign dif_t[i]    = lane_drv[i].t;
        assign dif_c[i]    = lane_drv[i].c;
        assign dif_t_oe[i] = lane_drv[i].t_oe;
        assign dif_c_oe[i] = lane_drv[i].c_oe;
    end

    p_pd_on_cfall_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(pd_park) |-> ph && !$past(pd_acc_n));

    p_pd_release_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(pd_park) |-> !ph && $past(pd_acc_n));

    p_pd_uniform_r3: assert property (@(posedge clk) disable iff (rst)
        pd_park |-> (dif_c_oe == '0) && (dif_c == '0)
                    && (dif_t_oe == {N_OUT{!pd_float}}));

    p_inv_held_r9: assert property (@(posedge clk) disable iff (rst)
        $stable(inv_q));
endmodule

// File: tb/ckgate_ctrl_tb.sv
module ckgate_ctrl_tb;
    localparam int CLK_P = 10;
    localparam int N     = 8;

    logic         clk = 1'b0;
    logic         rst;
    logic         pd_req_n, stop_req_n, oe_inv, pd_float, stop_float;
    logic [N-1:0] oe_pin, free_run;
    logic [N-1:0] dif_t, dif_c, dif_t_oe, dif_c_oe;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #(CLK_P/2) clk = !clk;

    ckgate_ctrl #(.N_OUT(N), .SYNC_STAGES(2)) u_dut (
        .clk (clk), .rst (rst), .pd_req_n (pd_req_n), .stop_req_n (stop_req_n),
        .oe_pin (oe_pin), .oe_inv (oe_inv), .pd_float (pd_float),
        .stop_float (stop_float), .free_run (free_run),
        .dif_t (dif_t), .dif_c (dif_c), .dif_t_oe (dif_t_oe), .dif_c_oe (dif_c_oe)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic wait_neg(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    // run: toggling pairs; stp: stopped pairs; rest must be off
    task automatic check_state(input logic [N-1:0] run, input logic [N-1:0] stp,
                               input logic sf, input string tag);
        logic [N-1:0] t0, c0, to0, co0, exp_t, exp_to;
        @(negedge clk);
        t0 = dif_t; c0 = dif_c; to0 = dif_t_oe; co0 = dif_c_oe;
        exp_t  = stp & {N{!sf}};
        exp_to = run | (stp & {N{!sf}});
        chk(to0 == exp_to, tag, to0, exp_to);
        chk(co0 == run, tag, co0, run);
        chk((t0 & ~run) == exp_t, tag, t0 & ~run, exp_t);
        chk((c0 & ~run) == '0, tag, c0 & ~run, 0);
        chk(((t0 ^ c0) & run) == run, tag, (t0 ^ c0) & run, run);
        @(negedge clk);
        chk(((t0 ^ dif_t) & run) == run, tag, (t0 ^ dif_t) & run, run);
    endtask

    task automatic check_pd(input logic pf, input string tag);
        @(negedge clk);
        chk(dif_t == {N{!pf}} && dif_t_oe == {N{!pf}}, tag, {dif_t, dif_t_oe},
            {{N{!pf}}, {N{!pf}}});
        chk(dif_c == '0 && dif_c_oe == '0, tag, {dif_c, dif_c_oe}, 0);
    endtask

    initial begin
        rst = 1'b1; pd_req_n = 1'b1; stop_req_n = 1'b1; oe_inv = 1'b0;
        pd_float = 1'b0; stop_float = 1'b0; oe_pin = '0; free_run = '0;

        for (int cfg = 0; cfg < 8; cfg++) begin
            logic inv, sf, pf;
            logic [N-1:0] en, fr, sm, fm;
            int fk, lat, got;
            logic prev_c, prev_t;
            inv = cfg[0]; sf = cfg[1]; pf = cfg[2];
            en  = ~(8'h01 << cfg);
            fr  = 8'h11 << (cfg % 4);
            sm  = en & ~fr;
            fm  = en & fr;
            fk  = 0;
            for (int b = N - 1; b >= 0; b--) if (fm[b]) fk = b;

            // Reset with this configuration
            @(negedge clk);
            rst = 1'b1; oe_inv = inv; oe_pin = en ^ {N{inv}};
            pd_float = pf; stop_float = sf; free_run = fr;
            pd_req_n = 1'b1; stop_req_n = 1'b1;
            wait_neg(3);
            chk(dif_t_oe == '0 && dif_c_oe == '0 && dif_t == '0 && dif_c == '0,
                "R10 reset state", {dif_t, dif_c, dif_t_oe, dif_c_oe}, 0);
            rst = 1'b0;
            wait_neg(10);
            check_state(en, '0, sf, "R8 enable pattern running");

            // R9: polarity pin changes after reset have no effect
            oe_inv = !inv;
            wait_neg(10);
            check_state(en, '0, sf, "R9 polarity held");
            oe_inv = inv;

            // R4: one-cycle stop glitch ignored
            stop_req_n = 1'b0; @(negedge clk); stop_req_n = 1'b1;
            for (int k = 0; k < 6; k++) check_state(en, '0, sf, "R4 stop glitch ignored");

            // R5/R7: stop accepted
            stop_req_n = 1'b0;
            wait_neg(14);
            check_state(fm, sm, sf, "R5 R7 stopped levels");

            // R4: one-cycle release glitch ignored
            stop_req_n = 1'b1; @(negedge clk); stop_req_n = 1'b0;
            for (int k = 0; k < 6; k++) check_state(fm, sm, sf, "R4 release glitch ignored");

            // R6: release latency and simultaneous resume
            stop_req_n = 1'b1;
            lat = 0;
            for (int k = 1; k <= 30; k++) begin
                @(negedge clk);
                if (lat == 0 && (dif_c_oe & sm) != '0) begin
                    lat = k;
                    chk((dif_c_oe & sm) == sm, "R6 all resume together",
                        dif_c_oe & sm, sm);
                end
            end
            chk(lat >= 4 && lat <= 12, "R6 release latency", lat, 8);
            check_state(en, '0, sf, "R6 running after release");

            // R1: one-cycle power-down glitch ignored
            pd_req_n = 1'b0; @(negedge clk); pd_req_n = 1'b1;
            for (int k = 0; k < 6; k++) check_state(en, '0, sf, "R1 pd glitch ignored");

            // R2: park on complement fall
            pd_req_n = 1'b0;
            got = 0;
            prev_c = dif_c[fk];
            for (int k = 0; k < 30; k++) begin
                @(negedge clk);
                if (got == 0 && ((pf == 1'b0 && dif_c_oe[fk] == 1'b0) ||
                                 (pf == 1'b1 && dif_t_oe[fk] == 1'b0))) begin
                    got = 1;
                    chk(prev_c == 1'b1, "R2 park follows complement high", prev_c, 1);
                    chk(dif_t[fk] == !pf, "R2 true level at park", dif_t[fk], !pf);
                end
                prev_c = dif_c[fk];
            end
            chk(got == 1, "R2 power-down parked", got, 1);
            check_pd(pf, "R3 power-down levels");

            // R3: stop request has no effect while powered down
            stop_req_n = 1'b0;
            wait_neg(14);
            check_pd(pf, "R3 pd dominates stop");
            stop_req_n = 1'b1;
            pd_req_n = 1'b1;
            wait_neg(16);
            check_state(en, '0, sf, "R1 running after power-up");

            // R8: enable changes only where true falls
            oe_pin[fk] = !oe_pin[fk];
            got = 0;
            prev_t = dif_t[fk];
            for (int k = 0; k < 12; k++) begin
                @(negedge clk);
                if (got == 0 && dif_t_oe[fk] == 1'b0) begin
                    got = 1;
                    chk(prev_t == 1'b1, "R8 disable at low phase", prev_t, 1);
                end
                prev_t = dif_t[fk];
            end
            chk(got == 1, "R8 pair disabled", got, 1);
            oe_pin[fk] = !oe_pin[fk];
            got = 0;
            for (int k = 0; k < 12; k++) begin
                @(negedge clk);
                if (got == 0 && dif_t_oe[fk] == 1'b1) begin
                    got = 1;
                    chk(dif_t[fk] == 1'b0, "R8 enable starts low", dif_t[fk], 0);
                end
            end
            chk(got == 1, "R8 pair re-enabled", got, 1);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule